// File: doc/BRIEF.md
# Guest Log Line Assembler

This block gathers text that guest software sends one byte at a time and turns it into whole lines. Two independent byte-write ports feed it. Each port holds a strobe and a data byte until the block acknowledges them. Accepted bytes collect in an internal line buffer. The buffer has `DEPTH` slots, and the top slot is kept for a zero terminator, so at most `DEPTH-1` payload bytes fit in one line.

A newline byte (0x0A) ends the current line and is never stored. A byte that arrives while all `DEPTH-1` payload slots are taken also ends the line, and that byte is thrown away. When a line ends, a zero byte is written at the current fill position and the fill position returns to zero. The finished line then drains on a valid/ready byte stream: first the payload bytes in arrival order, then the zero terminator, which carries the last-byte marker. An empty line therefore drains as one zero byte.

While a line drains, `busy` is high and neither write port is acknowledged. Synchronous reset throws away any partial line.

Top module: `log_line_asm`

## Requirements
- R1: After reset, `busy`, `line_valid`, `wr_a_ack` and `wr_b_ack` are low. Any bytes written before the reset are discarded, so a newline written after it yields an empty line.
- R2: A byte accepted from either port that is not 0x0A, and that arrives while fewer than `DEPTH-1` payload bytes are held, is stored. It appears in the drained line in arrival order.
- R3: An accepted 0x0A byte ends the line. It is not part of the output: the drained line is the stored bytes followed by one 0x00 byte with `line_last` high.
- R4: When `DEPTH-1` payload bytes are held, the next accepted byte (of any value) ends the line and is dropped. The drained line is exactly those `DEPTH-1` bytes plus the 0x00 terminator, and the dropped byte does not appear in the following line.
- R5: Ending a line with no payload drains exactly one byte, 0x00, with `line_last` high.
- R6: From the cycle after a line ends until its terminator is taken, `busy` and `line_valid` are high and neither `wr_a_ack` nor `wr_b_ack` is asserted. A strobe held through that time is accepted afterwards.
- R7: A port is acknowledged in the cycle its strobe is high and the block is not busy. When both strobes are high, port A is acknowledged and port B is not. The two acks are never high together.
- R8: While `line_valid` is high and `line_ready` is low, `line_data` and `line_last` hold their values.
- R9: `line_last` is high only on the terminator byte. In the cycle after the terminator is taken, `busy` and `line_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_a_stb | input | 1 | Port A byte-write strobe, held until acknowledged |
| wr_a_data | input | 8 | Port A byte |
| wr_a_ack | output | 1 | Port A byte taken this cycle |
| wr_b_stb | input | 1 | Port B byte-write strobe, held until acknowledged |
| wr_b_data | input | 8 | Port B byte |
| wr_b_ack | output | 1 | Port B byte taken this cycle |
| busy | output | 1 | A finished line is draining; writes are stalled |
| line_valid | output | 1 | Output byte valid |
| line_data | output | 8 | Output byte |
| line_last | output | 1 | Output byte is the line's terminator |
| line_ready | input | 1 | Consumer takes the output byte this cycle |

## Verification
A wrong fill position shows up at the ports when the line drains: bytes come out shifted, duplicated or missing, or the terminator arrives one byte early or late. This is seen in the first drain after the fault.

A miscounted full condition shows only at the boundary. Either a line of `DEPTH-1` bytes ends one byte too soon, or the extra byte leaks into the output or into the next line. The sweep over every line length, including the overflow case, therefore checks each byte position and the terminator position.

A drain state that fails to clear leaves `busy` high one cycle after the last byte is taken. A stall that fails to engage shows as an ack during a drain.

// File: rtl/loglin_pkg.sv
package loglin_pkg;
    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } st_e;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] NEWLINE_BYTE = 8'h0A;
    localparam logic [BYTE_W-1:0] TERM_BYTE    = 8'h00;
endpackage

// File: rtl/log_wr_arb.sv
module log_wr_arb #(
    parameter int unsigned DW = 8
) (
    input  logic          hold,
    input  logic          stb_a,
    input  logic [DW-1:0] data_a,
    input  logic          stb_b,
    input  logic [DW-1:0] data_b,
    output logic          ack_a,
    output logic          ack_b,
    output logic          take,
    output logic [DW-1:0] take_data
);
    // Fixed priority: port A first, port B only when A is idle.
    always_comb begin
        ack_a     = stb_a & ~hold;
        ack_b     = stb_b & ~stb_a & ~hold;
        take      = ack_a | ack_b;
        take_data = ack_a ? data_a : data_b;
    end
endmodule

// File: rtl/log_line_ram.sv
module log_line_ram #(
    parameter int unsigned DEPTH = 4096,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Combinational read: the drain pointer addresses the byte shown this cycle.
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/log_line_asm.sv
module log_line_asm
    import loglin_pkg::*;
#(
    parameter int unsigned DEPTH = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_a_stb,
    input  logic [7:0] wr_a_data,
    output logic       wr_a_ack,
    input  logic       wr_b_stb,
    input  logic [7:0] wr_b_data,
    output logic       wr_b_ack,
    output logic       busy,
    output logic       line_valid,
    output logic [7:0] line_data,
    output logic       line_last,
    input  logic       line_ready
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [AW-1:0] TOP_SLOT = AW'(DEPTH - 1);

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] wofs;
        logic [AW-1:0] rofs;
        logic [AW-1:0] end_ofs;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic        take;
    logic [7:0]  take_data;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;

    log_wr_arb #(.DW(BYTE_W)) u_arb (
        .hold      (ctl_q.st == ST_DRAIN),
        .stb_a     (wr_a_stb),
        .data_a    (wr_a_data),
        .stb_b     (wr_b_stb),
        .data_b    (wr_b_data),
        .ack_a     (wr_a_ack),
        .ack_b     (wr_b_ack),
        .take      (take),
        .take_data (take_data)
    );

    log_line_ram #(.DEPTH(DEPTH), .DW(BYTE_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ctl_q.wofs),
        .wdata (ram_wdata),
        .raddr (ctl_q.rofs),
        .rdata (ram_rdata)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ram_we    = 1'b0;
        ram_wdata = take_data;
        unique case (ctl_q.st)
            ST_FILL: begin
                if (take) begin
                    ram_we = 1'b1;
                    if (take_data == NEWLINE_BYTE || ctl_q.wofs == TOP_SLOT) begin
                        // End of line: terminator replaces the incoming byte.
                        ram_wdata     = TERM_BYTE;
                        ctl_d.end_ofs = ctl_q.wofs;
                        ctl_d.rofs    = '0;
                        ctl_d.st      = ST_DRAIN;
                    end else begin
                        ctl_d.wofs = ctl_q.wofs + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (line_ready) begin
                    if (ctl_q.rofs == ctl_q.end_ofs) begin
                        ctl_d.st   = ST_FILL;
                        ctl_d.wofs = '0;
                        ctl_d.rofs = '0;
                    end else begin
                        ctl_d.rofs = ctl_q.rofs + 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st      <= ST_FILL;
            ctl_q.wofs    <= '0;
            ctl_q.rofs    <= '0;
            ctl_q.end_ofs <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy       = (ctl_q.st == ST_DRAIN);
    assign line_valid = busy;
    assign line_data  = ram_rdata;
    assign line_last  = busy && (ctl_q.rofs == ctl_q.end_ofs);
endmodule

// File: rtl/log_line_asm_chk.sv
module log_line_asm_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_a_stb,
    input logic [7:0] wr_a_data,
    input logic       wr_a_ack,
    input logic       wr_b_stb,
    input logic       wr_b_ack,
    input logic       busy,
    input logic       line_valid,
    input logic [7:0] line_data,
    input logic       line_last,
    input logic       line_ready
);
    // R6
    a_r6_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!wr_a_ack && !wr_b_ack));

    // R7
    a_r7_one_ack: assert property (@(posedge clk) disable iff (rst)
        !(wr_a_ack && wr_b_ack));

    // R7
    a_r7_a_first: assert property (@(posedge clk) disable iff (rst)
        (wr_a_stb && wr_b_stb && !busy) |-> (wr_a_ack && !wr_b_ack));

    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (line_valid && !line_ready) |=>
            (line_valid && $stable(line_data) && $stable(line_last)));

    // R3
    a_r3_newline_ends: assert property (@(posedge clk) disable iff (rst)
        (wr_a_ack && wr_a_data == 8'h0A) |=> busy);

    // R9
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (line_valid && line_ready && line_last) |=> (!busy && !line_valid));

    // R9
    a_r9_term_zero: assert property (@(posedge clk) disable iff (rst)
        line_last |-> (line_valid && line_data == 8'h00));
endmodule

bind log_line_asm log_line_asm_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_a_stb   (wr_a_stb),
    .wr_a_data  (wr_a_data),
    .wr_a_ack   (wr_a_ack),
    .wr_b_stb   (wr_b_stb),
    .wr_b_ack   (wr_b_ack),
    .busy       (busy),
    .line_valid (line_valid),
    .line_data  (line_data),
    .line_last  (line_last),
    .line_ready (line_ready)
);

// File: tb/log_line_asm_test.sv
module log_line_asm_test;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_a_stb = 1'b0;
    logic [7:0] wr_a_data = 8'h00;
    logic       wr_a_ack;
    logic       wr_b_stb = 1'b0;
    logic [7:0] wr_b_data = 8'h00;
    logic       wr_b_ack;
    logic       busy;
    logic       line_valid;
    logic [7:0] line_data;
    logic       line_last;
    logic       line_ready = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [7:0] exp_q [16];

    always #(PERIOD/2) clk = ~clk;

    log_line_asm #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .wr_a_stb(wr_a_stb), .wr_a_data(wr_a_data), .wr_a_ack(wr_a_ack),
        .wr_b_stb(wr_b_stb), .wr_b_data(wr_b_data), .wr_b_ack(wr_b_ack),
        .busy(busy), .line_valid(line_valid), .line_data(line_data),
        .line_last(line_last), .line_ready(line_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input bit port_b, input logic [7:0] d);
        int guard = 0;
        @(negedge clk);
        if (port_b) begin wr_b_stb = 1'b1; wr_b_data = d; end
        else        begin wr_a_stb = 1'b1; wr_a_data = d; end
        #1;
        while (!(port_b ? wr_b_ack : wr_a_ack) && guard < 1000) begin
            @(negedge clk); #1; guard++;
        end
        @(posedge clk); #1;
        wr_a_stb = 1'b0;
        wr_b_stb = 1'b0;
    endtask

    // Drain n bytes and compare with exp_q; bp inserts ready stalls.
    task automatic drain(input int n, input bit bp, input string req);
        int got = 0;
        int cyc = 0;
        while (got < n && cyc < 1000) begin
            @(negedge clk);
            line_ready = bp ? ((cyc % 3) != 1) : 1'b1;
            cyc++;
            #1;
            if (line_valid) begin
                chk(line_data == exp_q[got], req, line_data, exp_q[got]);
                chk(line_last == (got == n - 1), "R9 last marker", line_last, got == n - 1);
                if (line_ready) got++;
            end
        end
        chk(got == n, req, got, n);
        @(negedge clk);
        line_ready = 1'b0;
        #1;
        chk(!busy && !line_valid, "R9 release", busy, 0);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !line_valid && !wr_a_ack && !wr_b_ack, "R1 reset state", busy, 0);
        rst = 1'b0;

        // R2 R3 R5: every line length, alternating ports, newline-terminated
        for (int len = 0; len < DEPTH; len++) begin
            for (int i = 0; i < len; i++) begin
                exp_q[i] = 8'h30 + 8'(len) + 8'(i);
                wr(i[0], exp_q[i]);
            end
            exp_q[len] = 8'h00;
            wr(len[0], 8'h0A);
            drain(len + 1, len[1], len == 0 ? "R5 empty line" : "R2 R3 line content");
        end

        // R4: full buffer, extra byte dropped
        for (int i = 0; i < DEPTH - 1; i++) begin
            exp_q[i] = 8'h61 + 8'(i);
            wr(1'b0, exp_q[i]);
        end
        exp_q[DEPTH-1] = 8'h00;
        wr(1'b1, 8'h55);
        drain(DEPTH, 1'b1, "R4 overflow line");
        exp_q[0] = 8'h00;
        wr(1'b0, 8'h0A);
        drain(1, 1'b0, "R4 dropped byte absent");

        // R6: stall during drain, held strobe accepted afterwards
        wr(1'b0, 8'h41);
        wr(1'b0, 8'h0A);
        @(negedge clk);
        wr_b_stb = 1'b1; wr_b_data = 8'h42;
        #1;
        chk(busy && line_valid && !wr_b_ack, "R6 stall while busy", wr_b_ack, 0);
        exp_q[0] = 8'h41; exp_q[1] = 8'h00;
        line_ready = 1'b1;
        @(negedge clk); #1;
        chk(busy && !wr_b_ack, "R6 stall while busy", wr_b_ack, 0);
        @(negedge clk); #1;
        chk(!busy && wr_b_ack, "R6 held byte accepted", wr_b_ack, 1);
        @(posedge clk); #1;
        wr_b_stb = 1'b0; line_ready = 1'b0;
        wr(1'b0, 8'h0A);
        exp_q[0] = 8'h42; exp_q[1] = 8'h00;
        drain(2, 1'b0, "R6 held byte stored");

        // R7: simultaneous strobes, A first
        @(negedge clk);
        wr_a_stb = 1'b1; wr_a_data = 8'h78;
        wr_b_stb = 1'b1; wr_b_data = 8'h79;
        #1;
        chk(wr_a_ack && !wr_b_ack, "R7 A priority", {wr_a_ack, wr_b_ack}, 2'b10);
        @(posedge clk); #1;
        wr_a_stb = 1'b0;
        @(negedge clk); #1;
        chk(wr_b_ack, "R7 B follows", wr_b_ack, 1);
        @(posedge clk); #1;
        wr_b_stb = 1'b0;
        wr(1'b0, 8'h0A);
        exp_q[0] = 8'h78; exp_q[1] = 8'h79; exp_q[2] = 8'h00;
        drain(3, 1'b1, "R7 order");

        // R1: reset discards a partial line
        wr(1'b0, 8'h33);
        wr(1'b1, 8'h34);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        chk(!busy && !line_valid, "R1 reset state", busy, 0);
        wr(1'b0, 8'h0A);
        exp_q[0] = 8'h00;
        drain(1, 1'b0, "R1 partial line discarded");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule